// File: doc/BRIEF.md
# Boot Source Priority Sequencer

This block is the control sequencer that runs once after reset to decide where the boot image comes from. First it programs the clock generator from a clock-select strap. Then it holds the low-voltage detector off while it requests trim loading. After that it probes five boot sources, one at a time and always in the same priority. Each source is probed through a simple start/done/valid handshake with an external probe engine. The first source that reports a valid image wins.

If none of the five reports a valid image, the sequencer raises the clock to a faster setting. It then probes a USB source over and over, without end, until that source reports a valid image. Once an image has been found, it asks the loader to copy the image. When the copy is done, it waits until a minimum interval has passed since trim setup, re-enables the low-voltage detector and raises a jump request. From that point on it reports the chosen source.

All pins are plain control and status levels or single-cycle pulses. No data passes through the block, so there is no back-pressure anywhere. Source bit order in `probe_sel` and `boot_src` is: bit 0 NOR flash, bit 1 NAND flash, bit 2 16-bit SPI EEPROM, bit 3 I2C EEPROM, bit 4 MMC/SD card, bit 5 USB.

Top module: `boot_seq_top`

## Requirements
- R1: While reset is held, `jump_req`, `load_req`, `probe_start`, `trim_req` and `lvd_en` are 0, `boot_src` is 0, `pll_en` is 0 and `pll_bypass` is 1.
- R2: After reset, `clk_sel`=0 gives `pll_en`=1, `pll_bypass`=0, `pll_mult`=375. `clk_sel`=1 gives `pll_en`=0, `pll_bypass`=1, so the external clock is used directly.
- R3: Sources are probed in the order bit 0, 1, 2, 3, 4, and `probe_sel` is one-hot on the source being probed. The first source that reports valid is chosen, and no later source is probed.
- R4: Only one probe is outstanding at a time: `probe_start` does not pulse again until `probe_done` has answered the previous probe.
- R5: `probe_ok` is sampled only in a cycle where `probe_done` is 1. At any other time it has no effect on the probe order or on `boot_src`.
- R6: If all five listed sources fail, the clock is reprogrammed before the first USB probe. With `clk_sel`=0 the result is `pll_mult`=1125 with the PLL on. With `clk_sel`=1 the result is `pll_en`=1, `pll_bypass`=0, `pll_mult`=3.
- R7: In fallback, only the USB source (bit 5) is probed, and it is probed again after every failure, for as long as it keeps failing.
- R8: `lvd_en` stays 0 from reset through trim loading. It stays 0 until at least `LVD_TICKS`+1 cycles after the cycle in which `trim_done` was sampled.
- R9: While in the USB fallback loop, `lvd_en` is raised once the `LVD_TICKS` interval since trim setup has expired.
- R10: `jump_req` rises only after `load_done`, no earlier than `LVD_TICKS`+1 cycles after `trim_done`, and with `lvd_en` already 1.
- R11: `boot_src` is one-hot on the chosen source from the cycle after the valid probe. From the jump request until reset, `boot_src` and `jump_req` hold, whatever the inputs do.
- R12: `trim_req` stays high from the end of reset until `trim_done`, and no probe starts before `trim_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 1 | Clock strap: 0 = PLL from 32768 Hz reference, 1 = external clock |
| pll_en | output | 1 | PLL power enable |
| pll_bypass | output | 1 | Route external clock around the PLL |
| pll_mult | output | MULT_W | PLL multiplier |
| trim_req | output | 1 | Request trim loading (level) |
| trim_done | input | 1 | Trim loading finished (pulse) |
| lvd_en | output | 1 | Low-voltage detector enable |
| probe_start | output | 1 | Start probing the selected source (pulse) |
| probe_sel | output | 6 | One-hot source being probed |
| probe_done | input | 1 | Probe finished (pulse) |
| probe_ok | input | 1 | Valid image found; meaningful only with probe_done |
| load_req | output | 1 | Copy the image from the chosen source (level) |
| load_done | input | 1 | Image copy finished (pulse) |
| boot_src | output | 6 | One-hot chosen source |
| jump_req | output | 1 | Branch to the loaded entry point (held) |

## Verification
The bench holds `probe_ok` high for several cycles before each `probe_done`. A design that samples the valid flag without the done pulse would lock onto the wrong source. It runs the all-fail path with both clock straps and checks the multiplier at the first USB probe. A design that switches the clock late, or to the wrong setting, shows a stale multiplier there. Short loads are finished well inside the timing window, so a design that jumps before the window has closed, or before the detector is back on, is caught. Long USB failure streams cross the window, so a design that never re-arms the detector inside the loop leaves `lvd_en` low.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;
  // Source index is also probe priority; the last index is the fallback.
  localparam int NUM_SRC = 6;
  localparam int USB_IDX = NUM_SRC - 1;
  localparam int LAST_LISTED = USB_IDX - 1;
  localparam int IDX_W = $clog2(NUM_SRC);

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_TRIM,
    ST_START,
    ST_WAIT,
    ST_RECLK,
    ST_LOAD,
    ST_HOLD,
    ST_JUMP
  } seq_state_t;
endpackage

// File: rtl/boot_clk_ctl.sv
`timescale 1ns/1ps
module boot_clk_ctl #(
  parameter int MULT_W    = 11,
  parameter int BASE_MULT = 375,
  parameter int FAST_MULT = 1125,
  parameter int EXT_MULT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic              sel_in,
  input  logic              go_fast,
  output logic              pll_en,
  output logic              pll_bypass,
  output logic [MULT_W-1:0] pll_mult
);
  logic sel_q;
  logic fast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      fast_q     <= 1'b0;
      pll_en     <= 1'b0;
      pll_bypass <= 1'b1;
      pll_mult   <= MULT_W'(1);
    end else if (latch) begin
      sel_q  <= sel_in;
      fast_q <= 1'b0;
      if (!sel_in) begin
        pll_en     <= 1'b1;
        pll_bypass <= 1'b0;
        pll_mult   <= MULT_W'(BASE_MULT);
      end else begin
        pll_en     <= 1'b0;
        pll_bypass <= 1'b1;
        pll_mult   <= MULT_W'(1);
      end
    end else if (go_fast && !fast_q) begin
      fast_q     <= 1'b1;
      pll_en     <= 1'b1;
      pll_bypass <= 1'b0;
      pll_mult   <= sel_q ? MULT_W'(EXT_MULT) : MULT_W'(FAST_MULT);
    end
  end

  // R6: fallback leaves the PLL powered and in the path
  a_r6_fast_clock_on: assert property (@(posedge clk) disable iff (!rst_n)
    go_fast |=> (pll_en && !pll_bypass));
  // R2: bypass and PLL power never both active
  a_r2_bypass_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass |-> !pll_en);
  // R2: multiplier only changes on a programming event
  a_r2_mult_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && !go_fast) |=> $stable(pll_mult));
endmodule

// File: rtl/boot_lvd_timer.sv
`timescale 1ns/1ps
module boot_lvd_timer #(
  parameter int LVD_TICKS = 2457600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trim_done,
  input  logic arm,
  output logic expired,
  output logic lvd_en
);
  localparam int CNT_W = $clog2(LVD_TICKS + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign expired = run_q && (cnt_q == CNT_W'(LVD_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (trim_done && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && !expired) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvd_en <= 1'b0;
    else if (arm && expired) lvd_en <= 1'b1;
  end

  // R8: detector only comes back after the window and a request to arm
  a_r8_lvd_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvd_en) |-> $past(arm && expired));
  // R8: detector off while the window has not started
  a_r8_lvd_off_pre_trim: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !lvd_en);
  // R9: the window saturates once expired
  a_r9_window_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);
endmodule

// File: rtl/boot_seq_fsm.sv
`timescale 1ns/1ps
module boot_seq_fsm
  import boot_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trim_done,
  input  logic     probe_done,
  input  logic     probe_ok,
  input  logic     load_done,
  input  logic     expired,
  output logic     clk_latch,
  output logic     clk_fast,
  output logic     lvd_arm,
  output logic     trim_req,
  output logic     probe_start,
  output src_vec_t probe_sel,
  output logic     load_req,
  output src_vec_t boot_src,
  output logic     jump_req
);
  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             usb_mode_q;
  logic             busy;

  assign busy = (state_q == ST_START) || (state_q == ST_WAIT);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    assign probe_sel[g] = busy && (idx_q == IDX_W'(g));
  end

  assign clk_latch   = (state_q == ST_INIT);
  assign clk_fast    = (state_q == ST_RECLK);
  assign trim_req    = (state_q == ST_TRIM);
  assign probe_start = (state_q == ST_START);
  assign load_req    = (state_q == ST_LOAD);
  assign jump_req    = (state_q == ST_JUMP);
  assign lvd_arm     = (state_q == ST_HOLD) || (usb_mode_q && busy);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_INIT:  state_d = ST_TRIM;
      ST_TRIM: begin
        if (trim_done) begin
          state_d = ST_START;
          idx_d   = '0;
        end
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (probe_done) begin
          if (probe_ok)                              state_d = ST_LOAD;
          else if (idx_q == IDX_W'(USB_IDX))         state_d = ST_START;
          else if (idx_q == IDX_W'(LAST_LISTED))     state_d = ST_RECLK;
          else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_START;
          end
        end
      end
      ST_RECLK: begin
        idx_d   = IDX_W'(USB_IDX);
        state_d = ST_START;
      end
      ST_LOAD:  if (load_done) state_d = ST_HOLD;
      ST_HOLD:  if (expired) state_d = ST_JUMP;
      ST_JUMP:  state_d = ST_JUMP;
      default:  state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_INIT;
      idx_q      <= '0;
      usb_mode_q <= 1'b0;
      boot_src   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (state_q == ST_RECLK) usb_mode_q <= 1'b1;
      if (state_q == ST_WAIT && probe_done && probe_ok) boot_src <= probe_sel;
    end
  end

  // R3: a failed listed probe moves to the very next source
  a_r3_next_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && probe_done && !probe_ok && idx_q < IDX_W'(LAST_LISTED))
      |=> (idx_q == $past(idx_q) + IDX_W'(1)));
  // R4: no new start while a probe is unanswered
  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !probe_done) |=> !probe_start);
  // R4: a start always names exactly one source
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    probe_start |-> $onehot(probe_sel));
  // R5: without done, the valid flag cannot change the choice
  a_r5_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !probe_done) |=> $stable(boot_src));
  // R7: fallback only ever probes the USB source
  a_r7_usb_only: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_mode_q && probe_start) |-> probe_sel[USB_IDX]);
  // R11: chosen source is one-hot and frozen from the jump on
  a_r11_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(boot_src));
  a_r11_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |=> (jump_req && $stable(boot_src)));
  // R12: no probe activity until trim has finished
  a_r12_trim_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIM && !trim_done) |=> !probe_start);
endmodule

// File: rtl/boot_seq_top.sv
`timescale 1ns/1ps
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int MULT_W    = 11,
  parameter int BASE_MULT = 375,
  parameter int FAST_MULT = 1125,
  parameter int EXT_MULT  = 3,
  parameter int LVD_TICKS = 2457600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_sel,
  output logic                pll_en,
  output logic                pll_bypass,
  output logic [MULT_W-1:0]   pll_mult,
  output logic                trim_req,
  input  logic                trim_done,
  output logic                lvd_en,
  output logic                probe_start,
  output logic [NUM_SRC-1:0]  probe_sel,
  input  logic                probe_done,
  input  logic                probe_ok,
  output logic                load_req,
  input  logic                load_done,
  output logic [NUM_SRC-1:0]  boot_src,
  output logic                jump_req
);
  logic clk_latch;
  logic clk_fast;
  logic lvd_arm;
  logic expired;

  boot_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trim_done   (trim_done),
    .probe_done  (probe_done),
    .probe_ok    (probe_ok),
    .load_done   (load_done),
    .expired     (expired),
    .clk_latch   (clk_latch),
    .clk_fast    (clk_fast),
    .lvd_arm     (lvd_arm),
    .trim_req    (trim_req),
    .probe_start (probe_start),
    .probe_sel   (probe_sel),
    .load_req    (load_req),
    .boot_src    (boot_src),
    .jump_req    (jump_req)
  );

  boot_clk_ctl #(
    .MULT_W    (MULT_W),
    .BASE_MULT (BASE_MULT),
    .FAST_MULT (FAST_MULT),
    .EXT_MULT  (EXT_MULT)
  ) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch      (clk_latch),
    .sel_in     (clk_sel),
    .go_fast    (clk_fast),
    .pll_en     (pll_en),
    .pll_bypass (pll_bypass),
    .pll_mult   (pll_mult)
  );

  boot_lvd_timer #(
    .LVD_TICKS (LVD_TICKS)
  ) u_lvd (
    .clk       (clk),
    .rst_n     (rst_n),
    .trim_done (trim_done),
    .arm       (lvd_arm),
    .expired   (expired),
    .lvd_en    (lvd_en)
  );

  // R10: the jump never precedes the detector re-enable
  a_r10_jump_with_lvd: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> lvd_en);
  // R6: USB probing always runs on a powered PLL
  a_r6_usb_on_pll: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_start && probe_sel[USB_IDX]) |-> (pll_en && !pll_bypass));
endmodule

// File: tb/sim_boot_seq_top.sv
`timescale 1ns/1ps
module sim_boot_seq_top;
  localparam int TICKS = 60;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_sel;
  logic       pll_en, pll_bypass;
  logic [10:0] pll_mult;
  logic       trim_req, trim_done, lvd_en;
  logic       probe_start, probe_done, probe_ok;
  logic [5:0] probe_sel, boot_src;
  logic       load_req, load_done, jump_req;

  always #2.5 clk = ~clk;

  boot_seq_top #(.LVD_TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .pll_en(pll_en), .pll_bypass(pll_bypass), .pll_mult(pll_mult),
    .trim_req(trim_req), .trim_done(trim_done), .lvd_en(lvd_en),
    .probe_start(probe_start), .probe_sel(probe_sel),
    .probe_done(probe_done), .probe_ok(probe_ok),
    .load_req(load_req), .load_done(load_done),
    .boot_src(boot_src), .jump_req(jump_req)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int t_trim = 0;
  bit trim_seen = 0;
  int mon_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // R8 monitor: detector must stay off until the window is over
  always @(negedge clk)
    if (rst_n && lvd_en && !(trim_seen && (cyc - t_trim >= TICKS + 1)))
      mon_bad++;

  always @(posedge clk)
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int first_ok(input logic [5:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) return i;
    return 5;
  endfunction

  function automatic int exp_clock(input logic sel, input bit fast);
    if (!fast) return sel ? {1'b0, 1'b1, 11'd1} : {1'b1, 1'b0, 11'd375};
    return sel ? {1'b1, 1'b0, 11'd3} : {1'b1, 1'b0, 11'd1125};
  endfunction

  task automatic run_case(input logic sel, input logic [5:0] okm, input int usb_fails,
                          input int trim_wait, input int load_wait);
    int exp_idx, usb_cnt, n, lat, winner;
    bit early, restart, fast_done, r9_done, ok, stable_bad;
    logic [5:0] held;
    winner = first_ok(okm);
    trim_seen = 0; mon_bad = 0;
    rst_n = 0; clk_sel = sel; trim_done = 0; probe_done = 0; probe_ok = 0; load_done = 0;
    repeat (3) @(negedge clk);
    chk({jump_req, load_req, probe_start, trim_req, lvd_en} == 5'b0 && boot_src == 6'b0
        && pll_en == 1'b0 && pll_bypass == 1'b1, "R1",
        {jump_req, load_req, probe_start, trim_req, lvd_en, pll_en, pll_bypass}, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({pll_en, pll_bypass, pll_mult} == 13'(exp_clock(sel, 0)), "R2",
        {pll_en, pll_bypass, pll_mult}, exp_clock(sel, 0));
    early = 0;
    for (int i = 0; i < trim_wait; i++) begin
      if (probe_start || !trim_req) early = 1;
      @(negedge clk);
    end
    chk(!early && trim_req && !probe_start, "R12", {early, trim_req, probe_start}, 3'b010);
    trim_done = 1;
    @(negedge clk);
    trim_done = 0; t_trim = cyc; trim_seen = 1;

    exp_idx = 0; usb_cnt = 0; restart = 0; fast_done = 0; r9_done = 0; ok = 0;
    while (!ok) begin
      n = 0;
      while (!probe_start && n < 40) begin @(negedge clk); n++; end
      chk(probe_start && probe_sel == (6'b1 << exp_idx), exp_idx == 5 ? "R7" : "R3",
          probe_sel, 6'b1 << exp_idx);
      if (!probe_start) return;
      if (exp_idx == 5 && !fast_done) begin
        fast_done = 1;
        chk({pll_en, pll_bypass, pll_mult} == 13'(exp_clock(sel, 1)), "R6",
            {pll_en, pll_bypass, pll_mult}, exp_clock(sel, 1));
      end
      if (exp_idx == 5 && usb_cnt >= 1 && !r9_done && (cyc - t_trim >= TICKS + 3)) begin
        r9_done = 1;
        chk(lvd_en, "R9", lvd_en, 1);
      end
      lat = $urandom_range(1, 5);
      probe_ok = 1;  // R5: valid without done must be ignored
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        if (probe_start) restart = 1;
      end
      ok = (exp_idx == 5) ? (usb_cnt == usb_fails) : okm[exp_idx];
      probe_done = 1; probe_ok = ok;
      @(negedge clk);
      probe_done = 0; probe_ok = 0;
      if (!ok) begin
        if (exp_idx == 5) usb_cnt++;
        else exp_idx++;
      end
    end
    chk(!restart, "R4", restart, 0);
    chk(exp_idx == winner, "R5", exp_idx, winner);
    chk(boot_src == (6'b1 << exp_idx) && load_req, "R11", boot_src, 6'b1 << exp_idx);
    early = 0;
    for (int i = 0; i < load_wait; i++) begin
      if (jump_req) early = 1;
      @(negedge clk);
    end
    load_done = 1;
    @(negedge clk);
    load_done = 0;
    chk(!early, "R10", early, 0);
    n = 0;
    while (!jump_req && n < TICKS + 20) begin @(negedge clk); n++; end
    chk(jump_req && (cyc - t_trim >= TICKS + 1) && lvd_en, "R10",
        cyc - t_trim, TICKS + 1);
    held = boot_src; stable_bad = 0;
    for (int i = 0; i < 12; i++) begin
      probe_done = 1'($urandom); probe_ok = 1'($urandom);
      load_done = 1'($urandom); trim_done = 1'($urandom);
      @(negedge clk);
      if (boot_src != held || !jump_req) stable_bad = 1;
    end
    probe_done = 0; probe_ok = 0; load_done = 0; trim_done = 0;
    chk(!stable_bad, "R11", boot_src, held);
    chk(mon_bad == 0, "R8", mon_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; clk_sel = 0; trim_done = 0; probe_done = 0; probe_ok = 0; load_done = 0;
    run_case(1'b0, 6'b000001, 0, 4, 2);   // first source wins
    run_case(1'b1, 6'b011000, 0, 0, 0);   // I2C beats MMC
    run_case(1'b0, 6'b010000, 0, 3, 1);   // last listed source
    run_case(1'b0, 6'b000000, 0, 2, 0);   // fallback, USB at once
    run_case(1'b1, 6'b100000, 20, 1, 3);  // long USB loop crosses window
    run_case(1'b0, 6'b000000, 25, 0, 90); // long load, long loop
    for (int k = 0; k < 8; k++)
      run_case(1'($urandom), 6'($urandom_range(0, 31) & $urandom_range(0, 31)),
               $urandom_range(0, 6), $urandom_range(0, 10), $urandom_range(0, 10));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule